// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits in front of a small on-chip word array and makes it behave like a parallel NOR flash part with the classic two-write unlock protocol. A host issues single-beat requests (read or write, byte address, data word) over a valid/ready request channel. Writes are decoded as multi-beat command sequences: program, sector erase, chip erase, identifier read, query-table read, unlock bypass and reset. Reads return array contents, identifier bytes, a status byte or query-table bytes, depending on the mode the sequencer is in.

Programming ANDs the write data into the addressed word, so bits can only be cleared. An erase first walks the selected range one word per clock, setting every word to all ones, and then holds a busy interval whose length (in clocks) is a parameter. A `fast_read` flag reports that the block is back in plain array-read mode: any write drops it, and it returns after a run of uninterrupted plain reads or when an erase completes.

Request rules: a request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low only while an erase fill is walking the array. Read responses carry no back-pressure: `rsp_valid` pulses for exactly one cycle, in the cycle after the read was taken, and the host must accept it then.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset every array word reads all ones, the sequencer is in plain read mode with bypass off, `busy` is 0, `req_ready` is 1, `fast_read` is 1 and the status byte is 0x00.
- R2: A taken read raises `rsp_valid` for one cycle on the next cycle; the word index is the byte address shifted right by log2(WORD_BYTES), and address bits above the array size are ignored, so addresses wrap modulo the chip size. The command offset is the low 8 bits of the word index and the command byte is `req_wdata[7:0]`.
- R3: The sequence 0xAA at offset UNLOCK_A0, 0x55 at offset UNLOCK_A1, 0xA0 at UNLOCK_A0 arms one program; the next write ANDs its data into the addressed word and the sequencer returns to read mode.
- R4: A write that breaks the unlock pattern (wrong data or wrong offset) returns the sequencer to read mode, so a following data write programs nothing.
- R5: 0xAA/0x55 unlock, 0x80 at UNLOCK_A0, a second 0xAA/0x55 unlock and then 0x30 at any address erases the sector holding that address: `req_ready` is low for SECTOR_WORDS cycles while the words are set to all ones, then `busy` stays high for SECTOR_BUSY_CYC more cycles; `busy` is high for the whole period.
- R6: In the same sequence, 0x10 at UNLOCK_A0 erases the whole array (WORDS fill cycles plus CHIP_BUSY_CYC); 0x10 at any other offset returns to read mode with no erase.
- R7: Writes taken during the erase busy interval, 0xF0 included, have no effect.
- R8: Reads in the armed-program state or the erase busy interval return the 8-bit status zero-extended: 0x00 after an erase starts, and 0x80 with bit 7 equal to the inverse of data bit 7 of the last programmed word.
- R9: After unlock and 0x90 at UNLOCK_A0, reads return ID_0 at offset 0x00, ID_1 at 0x01, 0x00 at 0x02 (no protected sector), ID_2 at 0x0E, ID_3 at 0x0F and 0x00 elsewhere.
- R10: 0x98 written at offset 0x55 from read mode or identifier mode enters query mode; reads then return 0x51, 0x52, 0x59 at offsets 0x10..0x12, 0x02 at 0x13, log2(chip bytes) at 0x27, 0x01 at 0x2C, NUM_SECTORS-1 at 0x2D (high byte at 0x2E), sector bytes/256 at 0x2F (next byte at 0x30), and 0x00 at every other offset; any write in query mode returns to read mode.
- R11: 0xF0 returns the sequencer to read mode from any non-busy state except the armed-program state, where it is ordinary program data.
- R12: Unlock and 0x20 at UNLOCK_A0 enter bypass mode, in which each command is a single write at any address; after a program the sequencer waits for the next command; 0x90 followed by 0x00 leaves bypass mode, after which commands again need the unlock pair.
- R13: Any taken write clears `fast_read`; it is set again after FAST_AFTER consecutive reads taken in plain read mode, or when an erase busy interval ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken; low during an erase fill |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | WORD_BYTES*8 | Write data; bits 7:0 carry the command byte |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_data | output | WORD_BYTES*8 | Read data |
| busy | output | 1 | Erase fill or erase interval in progress |
| fast_read | output | 1 | Plain array-read mode reached |

## Verification
Every result here is due a fixed number of edges after the request that causes it: read data and `rsp_valid` one cycle after the read is taken, a mode change on the edge that takes the write, `req_ready` low from that edge for exactly the fill length, and `busy` falling fill length plus busy interval edges later. The bench keeps a behavioural model that steps on the same edges and compares every output at each falling edge, so each of these latencies is checked exactly rather than with slack. Directed checks add hand-computed values at the same falling edge after each read, and the erase tests count the cycles `req_ready` is low and `busy` is high.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [3:0] {
    ST_READ, ST_UNL1, ST_CMD, ST_PROG, ST_ER_U0, ST_ER_U1,
    ST_ER_CMD, ST_ID, ST_CFI, ST_FILL, ST_WAIT
  } seq_state_e;

  localparam logic [7:0] CMD_UNLOCK_A  = 8'hAA;
  localparam logic [7:0] CMD_UNLOCK_B  = 8'h55;
  localparam logic [7:0] CMD_PROGRAM   = 8'hA0;
  localparam logic [7:0] CMD_ERASE     = 8'h80;
  localparam logic [7:0] CMD_IDENT     = 8'h90;
  localparam logic [7:0] CMD_BYPASS    = 8'h20;
  localparam logic [7:0] CMD_BYP_EXIT  = 8'h00;
  localparam logic [7:0] CMD_CHIP_ER   = 8'h10;
  localparam logic [7:0] CMD_SECT_ER   = 8'h30;
  localparam logic [7:0] CMD_QUERY     = 8'h98;
  localparam logic [7:0] CMD_RESET     = 8'hF0;
  localparam logic [7:0] QUERY_OFFSET  = 8'h55;

endpackage

// File: rtl/flash_cfi_rom.sv
module flash_cfi_rom #(
  parameter int NUM_SECTORS  = 4,
  parameter int SECTOR_BYTES = 128,
  parameter int CHIP_BYTES   = 512
) (
  input  logic [7:0] off,
  output logic [7:0] q
);
  localparam int SIZE_LOG2 = $clog2(CHIP_BYTES);

  always_comb begin
    unique case (off)
      8'h10:   q = 8'h51;
      8'h11:   q = 8'h52;
      8'h12:   q = 8'h59;
      8'h13:   q = 8'h02;
      8'h27:   q = 8'(SIZE_LOG2);
      8'h2C:   q = 8'h01;
      8'h2D:   q = 8'(NUM_SECTORS - 1);
      8'h2E:   q = 8'((NUM_SECTORS - 1) >> 8);
      8'h2F:   q = 8'(SECTOR_BYTES >> 8);
      8'h30:   q = 8'(SECTOR_BYTES >> 16);
      default: q = 8'h00;
    endcase
  end
endmodule

// File: rtl/flash_word_array.sv
module flash_word_array #(
  parameter int WORDS  = 256,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_en,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] prog_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (fill_en) begin
      mem[wr_idx] <= '1;
    end else if (prog_en) begin
      mem[wr_idx] <= mem[wr_idx] & prog_data;
    end
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expire = (cnt == CNT_W'(1));
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int WORD_BYTES      = 2,
  parameter int SECTOR_WORDS    = 64,
  parameter int NUM_SECTORS     = 4,
  parameter int ADDR_W          = 12,
  parameter logic [7:0] UNLOCK_A0 = 8'h55,
  parameter logic [7:0] UNLOCK_A1 = 8'hAA,
  parameter logic [7:0] ID_0    = 8'h01,
  parameter logic [7:0] ID_1    = 8'h7E,
  parameter logic [7:0] ID_2    = 8'h22,
  parameter logic [7:0] ID_3    = 8'h01,
  parameter int CHIP_BUSY_CYC   = 5_000_000,
  parameter int SECTOR_BUSY_CYC = 500_000,
  parameter int FAST_AFTER      = 42
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [WORD_BYTES*8-1:0] req_wdata,
  output logic                    rsp_valid,
  output logic [WORD_BYTES*8-1:0] rsp_data,
  output logic                    busy,
  output logic                    fast_read
);
  localparam int DATA_W   = WORD_BYTES * 8;
  localparam int WORDS    = SECTOR_WORDS * NUM_SECTORS;
  localparam int IDX_W    = $clog2(WORDS);
  localparam int BYTE_SH  = $clog2(WORD_BYTES);
  localparam int MAX_BUSY = (CHIP_BUSY_CYC > SECTOR_BUSY_CYC) ? CHIP_BUSY_CYC : SECTOR_BUSY_CYC;
  localparam int TMR_W    = $clog2(MAX_BUSY + 1);
  localparam int FC_W     = $clog2(FAST_AFTER + 1);
  localparam logic [IDX_W-1:0] SEC_MASK = IDX_W'(SECTOR_WORDS - 1);

  seq_state_e state, state_n;
  logic bypass, bypass_n;
  logic [7:0] status, status_n;
  logic [IDX_W-1:0] fill_ptr, fill_end;
  logic chip_sel;
  logic [FC_W-1:0] rd_cnt;

  logic acc, acc_wr, acc_rd;
  logic [IDX_W-1:0] idx;
  logic [7:0] off, cmd;
  logic prog_en, fill_go, fill_chip, fill_last, tmr_load, tmr_expire;
  logic [DATA_W-1:0] arr_q, rd_mux;
  logic [7:0] cfi_q, id_q;

  assign req_ready = (state != ST_FILL);
  assign busy      = (state == ST_FILL) || (state == ST_WAIT);
  assign acc       = req_valid && req_ready;
  assign acc_wr    = acc && req_write;
  assign acc_rd    = acc && !req_write;
  assign idx       = req_addr[BYTE_SH +: IDX_W];
  assign off       = 8'(idx);
  assign cmd       = req_wdata[7:0];
  assign fill_last = (state == ST_FILL) && (fill_ptr == fill_end);
  assign tmr_load  = fill_last;

  // Command decoder
  always_comb begin
    state_n   = state;
    bypass_n  = bypass;
    status_n  = status;
    prog_en   = 1'b0;
    fill_go   = 1'b0;
    fill_chip = 1'b0;
    if (acc_wr && state != ST_WAIT) begin
      if (state == ST_PROG) begin
        prog_en  = 1'b1;
        status_n = {~req_wdata[7], 7'b0};
        state_n  = bypass ? ST_CMD : ST_READ;
      end else if (cmd == CMD_RESET) begin
        state_n = ST_READ;
      end else begin
        unique case (state)
          ST_READ: begin
            if (off == QUERY_OFFSET && cmd == CMD_QUERY)      state_n = ST_CFI;
            else if (off == UNLOCK_A0 && cmd == CMD_UNLOCK_A) state_n = ST_UNL1;
          end
          ST_UNL1:  state_n = (off == UNLOCK_A1 && cmd == CMD_UNLOCK_B) ? ST_CMD : ST_READ;
          ST_CMD: begin
            if (!bypass && off != UNLOCK_A0) state_n = ST_READ;
            else begin
              unique case (cmd)
                CMD_PROGRAM: state_n = ST_PROG;
                CMD_ERASE:   state_n = ST_ER_U0;
                CMD_IDENT:   state_n = ST_ID;
                CMD_BYPASS:  begin bypass_n = 1'b1; state_n = ST_CMD; end
                default:     state_n = ST_READ;
              endcase
            end
          end
          ST_ER_U0: state_n = (off == UNLOCK_A0 && cmd == CMD_UNLOCK_A) ? ST_ER_U1 : ST_READ;
          ST_ER_U1: state_n = (off == UNLOCK_A1 && cmd == CMD_UNLOCK_B) ? ST_ER_CMD : ST_READ;
          ST_ER_CMD: begin
            if (cmd == CMD_CHIP_ER && off == UNLOCK_A0) begin
              fill_go = 1'b1; fill_chip = 1'b1; status_n = 8'h00; state_n = ST_FILL;
            end else if (cmd == CMD_SECT_ER) begin
              fill_go = 1'b1; status_n = 8'h00; state_n = ST_FILL;
            end else state_n = ST_READ;
          end
          ST_ID: begin
            if (bypass && cmd == CMD_BYP_EXIT)                  state_n = ST_READ;
            else if (off == QUERY_OFFSET && cmd == CMD_QUERY)   state_n = ST_CFI;
            else                                                state_n = ST_READ;
          end
          default: state_n = ST_READ;
        endcase
      end
    end
    if (fill_last)                          state_n = ST_WAIT;
    if (state == ST_WAIT && tmr_expire)     state_n = ST_READ;
    if (state_n == ST_READ)                 bypass_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_READ;
      bypass   <= 1'b0;
      status   <= 8'h00;
      fill_ptr <= '0;
      fill_end <= '0;
      chip_sel <= 1'b0;
    end else begin
      state  <= state_n;
      bypass <= bypass_n;
      status <= status_n;
      if (fill_go) begin
        chip_sel <= fill_chip;
        fill_ptr <= fill_chip ? '0 : (idx & ~SEC_MASK);
        fill_end <= fill_chip ? '1 : (idx | SEC_MASK);
      end else if (state == ST_FILL && !fill_last) begin
        fill_ptr <= fill_ptr + 1'b1;
      end
    end
  end

  // Plain-read run counter
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fast_read <= 1'b1;
      rd_cnt    <= '0;
    end else if (acc_wr) begin
      fast_read <= 1'b0;
      rd_cnt    <= '0;
    end else if (state == ST_WAIT && tmr_expire) begin
      fast_read <= 1'b1;
      rd_cnt    <= '0;
    end else if (acc_rd && state == ST_READ && !fast_read) begin
      if (rd_cnt == FC_W'(FAST_AFTER - 1)) begin
        fast_read <= 1'b1;
        rd_cnt    <= '0;
      end else begin
        rd_cnt <= rd_cnt + 1'b1;
      end
    end
  end

  flash_word_array #(.WORDS(WORDS), .DATA_W(DATA_W)) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_en   (prog_en),
    .fill_en   (state == ST_FILL),
    .wr_idx    (prog_en ? idx : fill_ptr),
    .prog_data (req_wdata),
    .rd_idx    (idx),
    .rd_data   (arr_q)
  );

  flash_busy_timer #(.CNT_W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (chip_sel ? TMR_W'(CHIP_BUSY_CYC) : TMR_W'(SECTOR_BUSY_CYC)),
    .expire   (tmr_expire)
  );

  flash_cfi_rom #(
    .NUM_SECTORS  (NUM_SECTORS),
    .SECTOR_BYTES (SECTOR_WORDS * WORD_BYTES),
    .CHIP_BYTES   (WORDS * WORD_BYTES)
  ) u_cfi (
    .off (off),
    .q   (cfi_q)
  );

  always_comb begin
    unique case (off)
      8'h00:   id_q = ID_0;
      8'h01:   id_q = ID_1;
      8'h0E:   id_q = ID_2;
      8'h0F:   id_q = ID_3;
      default: id_q = 8'h00;
    endcase
  end

  always_comb begin
    unique case (state)
      ST_PROG, ST_WAIT: rd_mux = DATA_W'(status);
      ST_ID:            rd_mux = DATA_W'(id_q);
      ST_CFI:           rd_mux = DATA_W'(cfi_q);
      default:          rd_mux = arr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= acc_rd;
      if (acc_rd) rsp_data <= rd_mux;
    end
  end
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic req_write,
  input logic rsp_valid,
  input logic busy,
  input logic fast_read
);
  // R2
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);

  // R2
  no_stray_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready && !req_write) |=> !rsp_valid);

  // R5
  stall_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> busy);

  // R5
  busy_starts_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !req_ready);

  // R13
  write_drops_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write) |=> !fast_read);

  // R13
  erase_end_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> fast_read);
endmodule

bind flash_cmd_seq flash_cmd_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .rsp_valid (rsp_valid),
  .busy      (busy),
  .fast_read (fast_read)
);

// File: tb/flash_cmd_seq_test.sv
module flash_cmd_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int SW   = 64;
  localparam int NS   = 4;
  localparam int NW   = SW * NS;
  localparam int CHIP_T = 300;
  localparam int SEC_T  = 30;
  localparam int U0 = 'h55;
  localparam int U1 = 'hAA;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [11:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rsp_valid, busy, fast_read;
  logic [15:0] rsp_data;

  int checks = 0, errors = 0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_seq #(
    .WORD_BYTES(2), .SECTOR_WORDS(SW), .NUM_SECTORS(NS), .ADDR_W(12),
    .CHIP_BUSY_CYC(CHIP_T), .SECTOR_BUSY_CYC(SEC_T), .FAST_AFTER(42)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .busy(busy), .fast_read(fast_read)
  );

  // ---------------- reference model ----------------
  localparam int M_READ=0, M_UNL1=1, M_CMD=2, M_PROG=3, M_EU0=4, M_EU1=5,
                 M_ECMD=6, M_ID=7, M_CFI=8, M_FILL=9, M_WAIT=10;
  int m_mode, m_cnt, m_tmr, m_ptr, m_end;
  bit m_byp, m_fast, m_chip, m_rv;
  logic [7:0] m_stat;
  logic [15:0] m_rd;
  logic [15:0] m_mem [NW];

  function automatic logic [7:0] id_exp(int o);
    case (o)
      0: return 8'h01;  1: return 8'h7E;  14: return 8'h22;  15: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] cfi_exp(int o);
    case (o)
      'h10: return 8'h51; 'h11: return 8'h52; 'h12: return 8'h59;
      'h13: return 8'h02; 'h27: return 8'd9;  'h2C: return 8'h01;
      'h2D: return 8'(NS - 1); 'h2F: return 8'((SW * 2) / 256);
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin : model
    int om, w, o;
    bit acc, aw;
    logic [7:0] c;
    if (!rst_n) begin
      m_mode = M_READ; m_byp = 0; m_fast = 1; m_cnt = 0; m_tmr = 0;
      m_stat = 8'h00; m_rv = 0; m_rd = '0;
      for (int i = 0; i < NW; i++) m_mem[i] = 16'hFFFF;
    end else begin
      om  = m_mode;
      acc = req_valid && (om != M_FILL);
      aw  = acc && req_write;
      w   = (req_addr / 2) % NW;
      o   = w % 256;
      c   = req_wdata[7:0];
      m_rv = acc && !req_write;
      if (m_rv) begin
        if (om == M_PROG || om == M_WAIT) m_rd = {8'h00, m_stat};
        else if (om == M_ID)  m_rd = {8'h00, id_exp(o)};
        else if (om == M_CFI) m_rd = {8'h00, cfi_exp(o)};
        else m_rd = m_mem[w];
      end
      if (aw) begin m_fast = 0; m_cnt = 0; end
      else if (om == M_WAIT && m_tmr == 1) begin m_fast = 1; m_cnt = 0; end
      else if (m_rv && om == M_READ && !m_fast) begin
        m_cnt++;
        if (m_cnt == 42) begin m_fast = 1; m_cnt = 0; end
      end
      if (om == M_FILL) begin
        m_mem[m_ptr] = 16'hFFFF;
        if (m_ptr == m_end) begin m_mode = M_WAIT; m_tmr = m_chip ? CHIP_T : SEC_T; end
        else m_ptr++;
      end else if (om == M_WAIT) begin
        m_tmr--;
        if (m_tmr == 0) m_mode = M_READ;
      end else if (aw) begin
        if (om == M_PROG) begin
          m_mem[w] = m_mem[w] & req_wdata;
          m_stat = req_wdata[7] ? 8'h00 : 8'h80;
          m_mode = m_byp ? M_CMD : M_READ;
        end else if (c == 8'hF0) m_mode = M_READ;
        else case (om)
          M_READ: if (o == 'h55 && c == 8'h98) m_mode = M_CFI;
                  else if (o == U0 && c == 8'hAA) m_mode = M_UNL1;
          M_UNL1: m_mode = (o == U1 && c == 8'h55) ? M_CMD : M_READ;
          M_CMD:  if (!m_byp && o != U0) m_mode = M_READ;
                  else if (c == 8'hA0) m_mode = M_PROG;
                  else if (c == 8'h80) m_mode = M_EU0;
                  else if (c == 8'h90) m_mode = M_ID;
                  else if (c == 8'h20) m_byp = 1;
                  else m_mode = M_READ;
          M_EU0:  m_mode = (o == U0 && c == 8'hAA) ? M_EU1 : M_READ;
          M_EU1:  m_mode = (o == U1 && c == 8'h55) ? M_ECMD : M_READ;
          M_ECMD: if (c == 8'h10 && o == U0) begin
                    m_mode = M_FILL; m_chip = 1; m_ptr = 0; m_end = NW - 1; m_stat = 0;
                  end else if (c == 8'h30) begin
                    m_mode = M_FILL; m_chip = 0; m_ptr = (w / SW) * SW; m_end = m_ptr + SW - 1; m_stat = 0;
                  end else m_mode = M_READ;
          M_ID:   if (m_byp && c == 8'h00) m_mode = M_READ;
                  else if (o == 'h55 && c == 8'h98) m_mode = M_CFI;
                  else m_mode = M_READ;
          default: m_mode = M_READ;
        endcase
      end
      if (m_mode == M_READ) m_byp = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(req_ready == (m_mode != M_FILL), tag, "req_ready", req_ready, m_mode != M_FILL);
      chk(busy == (m_mode >= M_FILL), tag, "busy", busy, m_mode >= M_FILL);
      chk(fast_read == m_fast, tag, "fast_read", fast_read, m_fast);
      chk(rsp_valid == m_rv, tag, "rsp_valid", rsp_valid, m_rv);
      if (m_rv) chk(rsp_data == m_rd, tag, "rsp_data", rsp_data, m_rd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input int widx, input logic [15:0] d);
    req_valid = 1; req_write = 1; req_addr = 12'(widx * 2); req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd_chk(input logic [11:0] baddr, input logic [15:0] exp, input string req);
    req_valid = 1; req_write = 0; req_addr = baddr;
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid && rsp_data == exp, req, "read data", rsp_data, exp);
  endtask

  task automatic unlock();
    wr(U0, 16'h00AA); wr(U1, 16'h0055);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int nb, nr;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    tag = "R1";
    chk(fast_read && !busy && req_ready, "R1", "idle flags", {fast_read, busy, req_ready}, 3'b101);
    rd_chk(12'(3 * 2), 16'hFFFF, "R1");

    // R3 program, then AND a second value
    tag = "R3";
    unlock(); wr(U0, 16'h00A0); wr(5, 16'h1234);
    rd_chk(12'(5 * 2), 16'h1234, "R3");
    unlock(); wr(U0, 16'h00A0); wr(5, 16'hFF00);
    rd_chk(12'(5 * 2), 16'h1200, "R3");

    // R2 address wrap
    tag = "R2";
    rd_chk(12'(5 * 2 + 12'h200), 16'h1200, "R2");

    // R4 broken unlock
    tag = "R4";
    wr(U0, 16'h00AA); wr(U1 + 1, 16'h0055); wr(U0, 16'h00A0); wr(6, 16'h0000);
    rd_chk(12'(6 * 2), 16'hFFFF, "R4");
    wr(U0, 16'h00AB); wr(U1, 16'h0055); wr(U0, 16'h00A0); wr(6, 16'h0000);
    rd_chk(12'(6 * 2), 16'hFFFF, "R4");

    // R8 status in armed program; R11 F0 as program data there
    tag = "R8";
    unlock(); wr(U0, 16'h00A0);
    rd_chk(12'(7 * 2), 16'h0080, "R8");
    tag = "R11";
    wr(7, 16'h00F0);
    rd_chk(12'(7 * 2), 16'h00F0, "R11");

    // R11 F0 aborts a sequence
    wr(U0, 16'h00AA); wr(U0, 16'h00F0); wr(U1, 16'h0055); wr(U0, 16'h00A0); wr(8, 16'h0000);
    rd_chk(12'(8 * 2), 16'hFFFF, "R11");

    // R9 identifier reads
    tag = "R9";
    unlock(); wr(U0, 16'h0090);
    rd_chk(12'(0), 16'h0001, "R9");
    rd_chk(12'(1 * 2), 16'h007E, "R9");
    rd_chk(12'(2 * 2), 16'h0000, "R9");
    rd_chk(12'(14 * 2), 16'h0022, "R9");
    rd_chk(12'(15 * 2), 16'h0001, "R9");
    rd_chk(12'(3 * 2), 16'h0000, "R9");

    // R10 query from identifier mode, then from read mode
    tag = "R10";
    wr('h55, 16'h0098);
    rd_chk(12'('h10 * 2), 16'h0051, "R10");
    rd_chk(12'('h11 * 2), 16'h0052, "R10");
    rd_chk(12'('h12 * 2), 16'h0059, "R10");
    rd_chk(12'('h27 * 2), 16'h0009, "R10");
    rd_chk(12'('h2D * 2), 16'h0003, "R10");
    rd_chk(12'('h60 * 2), 16'h0000, "R10");
    wr(3, 16'h0000);
    rd_chk(12'(5 * 2), 16'h1200, "R10");
    wr('h55, 16'h0098);
    rd_chk(12'('h13 * 2), 16'h0002, "R10");
    wr(U0, 16'h00F0);

    // R13 read run restores fast mode
    tag = "R13";
    for (int i = 0; i < 41; i++) rd_chk(12'(5 * 2), 16'h1200, "R13");
    chk(!fast_read, "R13", "fast_read after 41 reads", fast_read, 0);
    rd_chk(12'(5 * 2), 16'h1200, "R13");
    chk(fast_read, "R13", "fast_read after 42 reads", fast_read, 1);

    // R5 sector erase of sector 1
    tag = "R5";
    unlock(); wr(U0, 16'h00A0); wr(70, 16'h0F0F);
    unlock(); wr(U0, 16'h0080); unlock(); wr(70, 16'h0030);
    nb = 0; nr = 0;
    while (busy && nb < 2000) begin
      nb++;
      if (!req_ready) nr++;
      @(negedge clk);
    end
    chk(nr == SW, "R5", "fill cycles", nr, SW);
    chk(nb == SW + SEC_T, "R5", "busy cycles", nb, SW + SEC_T);
    chk(fast_read, "R13", "fast_read after erase", fast_read, 1);
    rd_chk(12'(70 * 2), 16'hFFFF, "R5");
    rd_chk(12'(5 * 2), 16'h1200, "R5");

    // R6 chip erase with wrong offset is refused
    tag = "R6";
    unlock(); wr(U0, 16'h0080); unlock(); wr(3, 16'h0010);
    chk(!busy, "R6", "busy after bad chip erase", busy, 0);
    rd_chk(12'(5 * 2), 16'h1200, "R6");

    // R6 chip erase; R7 writes ignored and R8 status during interval
    unlock(); wr(U0, 16'h0080); unlock(); wr(U0, 16'h0010);
    while (!req_ready) @(negedge clk);
    tag = "R7";
    wr(U0, 16'h00F0);
    wr(U0, 16'h00AA); wr(U1, 16'h0055); wr(U0, 16'h00A0); wr(9, 16'h0000);
    chk(busy, "R7", "busy after ignored writes", busy, 1);
    rd_chk(12'(9 * 2), 16'h0000, "R8");
    while (busy) @(negedge clk);
    tag = "R6";
    rd_chk(12'(5 * 2), 16'hFFFF, "R6");
    rd_chk(12'(9 * 2), 16'hFFFF, "R7");

    // R12 bypass
    tag = "R12";
    unlock(); wr(U0, 16'h0020);
    wr(200, 16'h00A0); wr(9, 16'h0F0F);
    rd_chk(12'(9 * 2), 16'h0F0F, "R12");
    wr(17, 16'h00A0); wr(10, 16'h3333);
    rd_chk(12'(10 * 2), 16'h3333, "R12");
    wr(3, 16'h0090); wr(3, 16'h0000);
    wr(U0, 16'h00A0); wr(11, 16'h0000);
    rd_chk(12'(11 * 2), 16'hFFFF, "R12");

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule